// File: doc/BRIEF.md
# Sensor Register-Access SPI Master

This block lets a processor read and write the registers of one external sensor over a four-wire serial link. Software sets up a transaction through a small register port. It gives the target register address, a direction flag, a count of bytes to send and a count of bytes to receive, and it loads the bytes to send into a transmit buffer. Software then sets the go bit. The block pulls the single active-low chip select low and builds a command byte from the direction flag, an automatic multi-byte flag and the address. It shifts out the command byte and the write bytes. It then shifts in the requested number of bytes into a receive buffer. At the end it releases chip select and sets a done flag, which can raise an interrupt.

The serial clock idles high. The block drives a new outgoing bit on each rising serial-clock edge, and it samples incoming data on each falling edge. Both directions run most significant bit first. The serial clock rate is the system clock divided by a parameter-derived even ratio. The register port has no back-pressure. A write strobe is taken in the cycle it is presented. Read data is a combinational function of the address and has no side effects.

Top module: `sensor_spi_master`

## Requirements
- R1: After reset, chip select and serial clock are high, the interrupt is low, and the status, control and count registers read 0.
- R2: The serial clock is high whenever chip select is high. Each clock phase lasts HALF = CLK_HZ/(2*SCLK_HZ) system cycles. Chip select falls HALF cycles before the first falling clock edge, and it rises HALF cycles after the last rising edge.
- R3: The outgoing line changes only on a rising serial-clock edge or when chip select falls. The incoming line is sampled on each falling edge. Bytes move MSB first.
- R4: The command byte is {dir, multi, addr[5:0]}. dir is bit 7 of the command register (1 = read). multi is 1 exactly when write count plus read count exceeds 1.
- R5: One transaction sends the command byte, then write-count bytes from transmit entries 0 upward, then read-count bytes. During the read bytes the outgoing line is 0, and the received bytes land in receive entries 0 upward. There are 8*(1+writes+reads) clock pulses in total.
- R6: The write count (offset 2) and read count (offset 3) saturate at DEPTH, so a larger value reads back as DEPTH.
- R7: Status (offset 4) bit 0 is busy while chip select is low. Status bit 1 (done) sets in the cycle chip select rises. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R8: The interrupt is high exactly while done is set and control (offset 0) bit 1, the interrupt enable, is set.
- R9: Writing control bit 0 (go) starts a transaction only when idle. A go written while busy has no effect.
- R10: The register map reads back as follows. Control bit 1 holds the interrupt enable. The command register (offset 1) holds {dir, 0, addr}. Transmit entries sit at DEPTH+i and are readable. Receive entries sit at 2*DEPTH+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | $clog2(DEPTH)+2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt: done and enabled |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_ss_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The timing assertions assume HALF is at least 2, so that every serial-clock phase spans several system cycles and a change can be told apart from a hold. They also assume spi_miso is already synchronous or slow enough to sample directly. The bench's sensor model changes spi_miso only on rising serial-clock edges, which is half a period away from the sampling edge. The counts and the transmit buffer are taken as fixed while a transaction runs. The stimulus therefore rewrites them only between transactions, and the only write it makes mid-transaction is the deliberately ignored go.

// File: rtl/sensor_spi_pkg.sv
package sensor_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } xfer_state_t;

  // control-region offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_CMD  = 1;
  localparam int OFF_WCNT = 2;
  localparam int OFF_RCNT = 3;
  localparam int OFF_STAT = 4;

  localparam int CTRL_GO     = 0;
  localparam int CTRL_IEN    = 1;
  localparam int STAT_BUSY   = 0;
  localparam int STAT_DONE   = 1;
  localparam int CMD_DIR_BIT = 7;

  function automatic logic [7:0] make_cmd(input logic dir, input logic multi,
                                          input logic [5:0] addr);
    return {dir, multi, addr};
  endfunction
endpackage

// File: rtl/ssm_halfbit_timer.sv
module ssm_halfbit_timer #(
  parameter int HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/ssm_regfile.sv
module ssm_regfile
  import sensor_spi_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int ADDR_W = IDXW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              go,
  input  logic              busy,
  input  logic              done_set,
  input  logic              rx_we,
  input  logic [IDXW-1:0]   rx_idx,
  input  logic [7:0]        rx_data,
  input  logic [IDXW-1:0]   tx_idx,
  output logic [7:0]        tx_data,
  output logic              cmd_rd,
  output logic [5:0]        cmd_addr,
  output logic [CNTW-1:0]   wr_cnt,
  output logic [CNTW-1:0]   rd_cnt,
  output logic              done,
  output logic              irq
);
  logic [1:0]      region;
  logic [IDXW-1:0] off;
  logic            ctl_sel, tx_sel, rx_sel;
  logic            ien_q;
  logic [7:0]      tx_mem [DEPTH];
  logic [7:0]      rx_mem [DEPTH];

  assign region  = bus_addr[ADDR_W-1:IDXW];
  assign off     = bus_addr[IDXW-1:0];
  assign ctl_sel = (region == 2'd0);
  assign tx_sel  = (region == 2'd1);
  assign rx_sel  = (region == 2'd2);

  assign go      = bus_wr && ctl_sel && (off == IDXW'(OFF_CTRL)) && bus_wdata[CTRL_GO];
  assign tx_data = tx_mem[tx_idx];
  assign irq     = done && ien_q;

  function automatic logic [CNTW-1:0] clamp(input logic [7:0] v);
    return (v > 8'(DEPTH)) ? CNTW'(DEPTH) : v[CNTW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      wr_cnt   <= '0;
      rd_cnt   <= '0;
      done     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i] <= '0;
        rx_mem[i] <= '0;
      end
    end else begin
      if (bus_wr && ctl_sel) begin
        if (off == IDXW'(OFF_CTRL)) ien_q <= bus_wdata[CTRL_IEN];
        if (off == IDXW'(OFF_CMD)) begin
          cmd_rd   <= bus_wdata[CMD_DIR_BIT];
          cmd_addr <= bus_wdata[5:0];
        end
        if (off == IDXW'(OFF_WCNT)) wr_cnt <= clamp(bus_wdata);
        if (off == IDXW'(OFF_RCNT)) rd_cnt <= clamp(bus_wdata);
      end
      if (bus_wr && tx_sel) tx_mem[off] <= bus_wdata;
      if (rx_we) rx_mem[rx_idx] <= rx_data;
      if (done_set)
        done <= 1'b1;
      else if (bus_wr && ctl_sel && (off == IDXW'(OFF_STAT)) && bus_wdata[STAT_DONE])
        done <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctl_sel) begin
      if (off == IDXW'(OFF_CTRL))      bus_rdata[CTRL_IEN] = ien_q;
      else if (off == IDXW'(OFF_CMD))  bus_rdata = {cmd_rd, 1'b0, cmd_addr};
      else if (off == IDXW'(OFF_WCNT)) bus_rdata = 8'(wr_cnt);
      else if (off == IDXW'(OFF_RCNT)) bus_rdata = 8'(rd_cnt);
      else if (off == IDXW'(OFF_STAT)) begin
        bus_rdata[STAT_BUSY] = busy;
        bus_rdata[STAT_DONE] = done;
      end
    end else if (tx_sel) begin
      bus_rdata = tx_mem[off];
    end else if (rx_sel) begin
      bus_rdata = rx_mem[off];
    end
  end
endmodule

// File: rtl/ssm_engine.sv
module ssm_engine
  import sensor_spi_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(2 * DEPTH + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            cmd_rd,
  input  logic [5:0]      cmd_addr,
  input  logic [CNTW-1:0] wr_cnt,
  input  logic [CNTW-1:0] rd_cnt,
  output logic [IDXW-1:0] tx_idx,
  input  logic [7:0]      tx_data,
  input  logic            tick,
  output logic            run,
  output logic            busy,
  output logic            done_set,
  output logic            rx_we,
  output logic [IDXW-1:0] rx_idx,
  output logic [7:0]      rx_data,
  output logic            sclk,
  output logic            ss_n,
  output logic            mosi,
  input  logic            miso
);
  xfer_state_t state;
  logic [7:0]  shreg, shin;
  logic [BW-1:0] byte_q, w_q, tot_q;
  logic [2:0]  bit_q;
  logic        multi;

  assign busy     = (state != ST_IDLE);
  assign run      = busy;
  assign mosi     = shreg[7];
  assign tx_idx   = IDXW'(byte_q);
  assign multi    = (BW'(wr_cnt) + BW'(rd_cnt)) > BW'(1);
  assign done_set = (state == ST_TRAIL) && tick;
  assign rx_we    = (state == ST_LOW) && tick && (bit_q == 3'd7) && (byte_q > w_q);
  assign rx_idx   = IDXW'(byte_q - w_q - BW'(1));
  assign rx_data  = shin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sclk   <= 1'b1;
      ss_n   <= 1'b1;
      shreg  <= '0;
      shin   <= '0;
      byte_q <= '0;
      bit_q  <= '0;
      w_q    <= '0;
      tot_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state  <= ST_LEAD;
          ss_n   <= 1'b0;
          shreg  <= make_cmd(cmd_rd, multi, cmd_addr);
          byte_q <= '0;
          bit_q  <= '0;
          w_q    <= BW'(wr_cnt);
          tot_q  <= BW'(1) + BW'(wr_cnt) + BW'(rd_cnt);
        end
        ST_LEAD, ST_HIGH: if (tick) begin
          state <= ST_LOW;
          sclk  <= 1'b0;
          shin  <= {shin[6:0], miso};
        end
        ST_LOW: if (tick) begin
          sclk <= 1'b1;
          if (bit_q == 3'd7) begin
            bit_q <= '0;
            if (byte_q == tot_q - BW'(1)) begin
              state <= ST_TRAIL;
            end else begin
              state  <= ST_HIGH;
              byte_q <= byte_q + BW'(1);
              shreg  <= (byte_q < w_q) ? tx_data : 8'h00;
            end
          end else begin
            state <= ST_HIGH;
            bit_q <= bit_q + 3'd1;
            shreg <= {shreg[6:0], 1'b0};
          end
        end
        ST_TRAIL: if (tick) begin
          state <= ST_IDLE;
          ss_n  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sensor_spi_master.sv
module sensor_spi_master #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int SCLK_HZ = 1_000_000,
  parameter int DEPTH   = 8,
  localparam int ADDR_W = $clog2(DEPTH) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_ss_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int HALF = CLK_HZ / (2 * SCLK_HZ);
  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            go, busy, done_flag, done_set, tick, run, rx_we, cmd_rd;
  logic [5:0]      cmd_addr;
  logic [CNTW-1:0] wr_cnt, rd_cnt;
  logic [IDXW-1:0] tx_idx, rx_idx;
  logic [7:0]      tx_data, rx_data;

  ssm_regfile #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .go(go), .busy(busy),
    .done_set(done_set), .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data),
    .tx_idx(tx_idx), .tx_data(tx_data), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .done(done_flag), .irq(irq)
  );

  ssm_halfbit_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ssm_engine #(.DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .tx_idx(tx_idx), .tx_data(tx_data),
    .tick(tick), .run(run), .busy(busy), .done_set(done_set), .rx_we(rx_we),
    .rx_idx(rx_idx), .rx_data(rx_data), .sclk(spi_sclk), .ss_n(spi_ss_n),
    .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/sensor_spi_checker.sv
module sensor_spi_checker #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int SCLK_HZ = 1_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic ss_n,
  input logic mosi,
  input logic done
);
  localparam int HALF = CLK_HZ / (2 * SCLK_HZ);

  logic [15:0] run_len;
  logic        prev_sclk, prev_ss;

  // cycles since the last change on either line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      prev_sclk <= 1'b1;
      prev_ss   <= 1'b1;
    end else begin
      prev_sclk <= sclk;
      prev_ss   <= ss_n;
      if (sclk != prev_sclk || ss_n != prev_ss) run_len <= 16'd1;
      else if (run_len != 16'hFFFF)             run_len <= run_len + 16'd1;
    end
  end

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> sclk); // R2
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && sclk != $past(sclk)) |-> $past(run_len) == 16'(HALF - 1)); // R2
  AST_CS_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> ($past(run_len) == 16'(HALF - 1) && $past(sclk))); // R2
  AST_MOSI_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && !sclk && !$past(sclk)) |-> $stable(mosi)); // R3
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $rose(ss_n)); // R7
endmodule

bind sensor_spi_master sensor_spi_checker #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .ss_n(spi_ss_n),
  .mosi(spi_mosi), .done(done_flag)
);

// File: tb/sim_sensor_spi_master.sv
module sim_sensor_spi_master;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 40;
  localparam int SCLK_HZ = 5;
  localparam int DEPTH   = 8;
  localparam int HALF    = CLK_HZ / (2 * SCLK_HZ);
  localparam int AW      = $clog2(DEPTH) + 2;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sclk, spi_ss_n, spi_mosi, spi_miso;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sensor_spi_master #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---- sensor model: samples MOSI on falling, updates MISO on rising
  bit [7:0] sl_seed = 8'h00;
  int sidx = 0;
  bit cap[$];
  logic prev_ss = 1'b1, prev_sck = 1'b1;

  function automatic bit [7:0] pat_byte(input bit [7:0] seed, input int j);
    return 8'hA5 ^ 8'(j * 59) ^ seed;
  endfunction
  function automatic logic pat_bit(input bit [7:0] seed, input int idx);
    bit [7:0] b;
    b = pat_byte(seed, idx / 8);
    return b[7 - (idx % 8)];
  endfunction

  assign spi_miso = pat_bit(sl_seed, sidx);

  always @(spi_sclk, spi_ss_n) begin
    if (spi_ss_n !== prev_ss && spi_ss_n === 1'b0) begin
      sidx = 0;
      cap.delete();
    end else if (spi_ss_n === 1'b0 && spi_sclk !== prev_sck) begin
      if (spi_sclk === 1'b0) cap.push_back(spi_mosi);
      else sidx++;
    end
    prev_ss  = spi_ss_n;
    prev_sck = spi_sclk;
  end

  // ---- cycle-by-cycle timing model
  int mt = -1, mtot = 0, m_w = 0, m_r = 0;

  always @(posedge clk) begin
    bit st;
    if (!rst_n) mt = -1;
    else begin
      st = (mt < 0) && bus_wr && (bus_addr == '0) && bus_wdata[0];
      if (mt >= 0) begin
        mt++;
        if (mt >= mtot) mt = -1;
      end
      if (st) begin
        mt = 0;
        mtot = HALF * (16 * (1 + m_w + m_r) + 1);
      end
    end
  end

  always @(negedge clk) begin
    logic e_ss, e_sck;
    if (rst_n && !finished) begin
      if (mt < 0) begin e_ss = 1; e_sck = 1; end
      else begin
        e_ss = 0;
        e_sck = (mt < HALF) ? 1'b1 : 1'(((mt - HALF) / HALF) % 2);
      end
      chk(spi_ss_n === e_ss, "R2 chip select timing", spi_ss_n, e_ss);
      chk(spi_sclk === e_sck, "R2 serial clock timing", spi_sclk, e_sck);
    end
  end

  // ---- bus tasks
  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    if (a == 2) m_w = (d > DEPTH) ? DEPTH : d;
    if (a == 3) m_r = (d > DEPTH) ? DEPTH : d;
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic reg_rd(input int a, output bit [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  function automatic bit [7:0] tx_byte(input bit [7:0] seed, input int i);
    return 8'h1F + seed + 8'(i * 17);
  endfunction

  task automatic setup(input bit [5:0] ra, input bit rd, input int w, input int r,
                       input bit [7:0] seed);
    sl_seed = seed;
    reg_wr(1, {rd, 1'b0, ra});
    reg_wr(2, w);
    reg_wr(3, r);
    for (int i = 0; i < DEPTH; i++) reg_wr(DEPTH + i, tx_byte(seed, i));
  endtask

  task automatic finish_check(input bit [5:0] ra, input bit rd, input bit [7:0] seed,
                              input bit ien);
    bit [7:0] d, e, got;
    int n;
    while (mt >= 0) @(negedge clk);
    @(negedge clk);
    n = 1 + m_w + m_r;
    chk(cap.size() == 8 * n, "R5 clock pulse count", cap.size(), 8 * n);
    for (int k = 0; k < n && 8 * k + 7 < cap.size(); k++) begin
      for (int b = 0; b < 8; b++) got[7 - b] = cap[8 * k + b];
      if (k == 0) begin
        e = {rd, (m_w + m_r > 1) ? 1'b1 : 1'b0, ra};
        chk(got == e, "R4 command byte", got, e);
      end else if (k <= m_w) begin
        e = tx_byte(seed, k - 1);
        chk(got == e, "R5 write byte order", got, e);
      end else begin
        chk(got == 8'h00, "R5 MOSI low during read bytes", got, 0);
      end
    end
    for (int k = 0; k < m_r; k++) begin
      reg_rd(2 * DEPTH + k, d);
      e = pat_byte(seed, 1 + m_w + k);
      chk(d == e, "R3 receive capture MSB first", d, e);
    end
    reg_rd(4, d);
    chk(d == 8'h02, "R7 done set busy clear", d, 2);
    chk(irq == ien, "R8 interrupt level", irq, ien);
  endtask

  task automatic txn(input bit [5:0] ra, input bit rd, input int w, input int r,
                     input bit [7:0] seed, input bit ien);
    setup(ra, rd, w, r, seed);
    reg_wr(0, {6'b0, ien, 1'b1});
    finish_check(ra, rd, seed, ien);
    reg_wr(4, 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk(spi_ss_n === 1'b1, "R1 chip select after reset", spi_ss_n, 1);
    chk(spi_sclk === 1'b1, "R1 clock after reset", spi_sclk, 1);
    chk(irq === 1'b0, "R1 interrupt after reset", irq, 0);
    reg_rd(4, d); chk(d == 0, "R1 status after reset", d, 0);
    reg_rd(0, d); chk(d == 0, "R1 control after reset", d, 0);
    reg_rd(2, d); chk(d == 0, "R1 write count after reset", d, 0);

    // R10 register map
    reg_wr(1, 8'hB5); reg_rd(1, d); chk(d == 8'hB5 - 8'h00 && d[6] == 0, "R10 command readback", d, 8'hB5);
    reg_wr(1, 8'h7F); reg_rd(1, d); chk(d == 8'h3F, "R10 command bit6 not stored", d, 8'h3F);
    reg_wr(DEPTH + 3, 8'h5C); reg_rd(DEPTH + 3, d); chk(d == 8'h5C, "R10 transmit entry readback", d, 8'h5C);
    reg_wr(0, 8'h02); reg_rd(0, d); chk(d == 8'h02, "R10 enable readback", d, 2);
    chk(spi_ss_n === 1'b1, "R10 enable write does not start", spi_ss_n, 1);
    reg_wr(0, 8'h00);

    // R6 saturation
    reg_wr(2, 12); reg_rd(2, d); chk(d == DEPTH, "R6 write count saturates", d, DEPTH);
    reg_wr(3, 200); reg_rd(3, d); chk(d == DEPTH, "R6 read count saturates", d, DEPTH);

    // transactions of various shapes (R4 R5 R3 R7 R8)
    txn(6'h31, 1'b0, 1, 0, 8'h11, 1'b1);  // single write, multi clear
    txn(6'h00, 1'b1, 0, 1, 8'h22, 1'b0);  // single read
    txn(6'h32, 1'b1, 0, 6, 8'h33, 1'b1);  // burst read, multi set
    txn(6'h1E, 1'b0, 3, 0, 8'h44, 1'b1);  // burst write
    txn(6'h2A, 1'b1, 2, 2, 8'h55, 1'b0);  // mixed
    txn(6'h0F, 1'b0, 0, 0, 8'h66, 1'b1);  // command only
    txn(6'h3F, 1'b1, 12, 9, 8'h77, 1'b1); // saturated counts, 17 bytes

    // R9 go while busy ignored
    setup(6'h15, 1'b1, 1, 1, 8'h88);
    reg_wr(0, 8'h03);
    repeat (HALF * 10) @(negedge clk);
    reg_rd(4, d); chk(d[0] == 1'b1, "R7 busy during transaction", d, 1);
    reg_wr(0, 8'h03);
    finish_check(6'h15, 1'b1, 8'h88, 1'b1);
    repeat (3 * HALF) @(negedge clk);
    chk(spi_ss_n === 1'b1, "R9 no restart after ignored go", spi_ss_n, 1);

    // R7 write-one-to-clear, R8 enable gating
    reg_wr(4, 8'h01); reg_rd(4, d); chk(d == 8'h02, "R7 writing zero keeps done", d, 2);
    chk(irq === 1'b1, "R8 interrupt while done and enabled", irq, 1);
    reg_wr(0, 8'h00); #1 chk(irq === 1'b0, "R8 interrupt masked", irq, 0);
    reg_rd(4, d); chk(d == 8'h02, "R8 masking keeps done", d, 2);
    reg_wr(0, 8'h02); #1 chk(irq === 1'b1, "R8 interrupt re-enabled", irq, 1);
    reg_wr(4, 8'h02); reg_rd(4, d); chk(d == 8'h00, "R7 done cleared", d, 0);
    chk(irq === 1'b0, "R8 interrupt drops with done", irq, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule